// File: doc/BRIEF.md
# Issue Hazard Scoreboard

This block decides, one candidate instruction per cycle, whether an in-order pipeline may send that instruction to its functional units. The pipeline has several execution units with different latencies. Results can therefore come back out of program order, and a short operation may finish before a long one that issued earlier. Operands are read in program order, so a later instruction can never overwrite a register before an earlier one has read it. That leaves three checks for this block: a read-after-write hazard on a source, a write-after-write hazard on the destination, and a conflict on a shared resource.

The block keeps one reservation flag per architectural register. It also tracks whether the non-pipelined divider is busy, and it keeps a bit per future cycle that records when the single register write port is already claimed. Each cycle the issue stage presents an operation class, two source registers and a destination register. The block answers combinationally with a grant and with the individual hold reasons. A grant claims the destination register and the write-port cycle of the result, and for a divide it also claims the divider. The writeback side reports each completed register, and that report lifts the register's reservation.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset no register is reserved, the divider is idle and no write-port cycle is claimed, so any valid candidate is granted.
- R2: A candidate whose source register (not register 0) is reserved is held with `stall_raw` high and `issue_grant` low.
- R3: A candidate whose destination register (not register 0) is reserved is held with `stall_waw` high and `issue_grant` low.
- R4: A reservation is set only by a granted instruction. A held candidate, or a candidate with `issue_valid` low, reserves nothing.
- R5: A writeback report (`wb_valid`, `wb_reg`) clears that register's reservation. In the same cycle as the report, a candidate that reads or writes that register is not held for it.
- R6: Register 0 is never reserved. A candidate with destination 0 claims no register and no write-port cycle, and a source or destination of 0 never causes a hold.
- R7: Operation class 3 is a divide with latency 25 that is not pipelined. After a divide is granted in cycle t, every further divide is held with `stall_unit` high through cycle t+24, and a divide may be granted again in cycle t+25.
- R8: Operation classes 0 (integer, latency 1), 1 (add, latency 4) and 2 (multiply, latency 7) are pipelined. The same class may be granted in consecutive cycles, and these classes are not held while the divider is busy.
- R9: A granted instruction with latency L and a nonzero destination claims the write port for cycle t+L. A later candidate whose result would land in a cycle that is already claimed is held with `stall_port` high.
- R10: With `issue_valid` low, `issue_grant` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | A candidate instruction is presented |
| issue_op | input | 2 | Operation class: 0 integer, 1 add, 2 multiply, 3 divide |
| issue_src_a | input | 5 | First source register |
| issue_src_b | input | 5 | Second source register |
| issue_dst | input | 5 | Destination register, 0 for no result |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_reg | input | 5 | Register written back |
| issue_grant | output | 1 | The candidate issues this cycle |
| stall_raw | output | 1 | Held: a source is reserved |
| stall_waw | output | 1 | Held: the destination is reserved |
| stall_unit | output | 1 | Held: divide requested while the divider is busy |
| stall_port | output | 1 | Held: write port already claimed for the result cycle |

## Verification
The grant and the four hold flags are combinational, so each reflects the inputs of the current cycle. State changes caused by a grant or by a writeback report become visible in the next cycle. The bench drives every candidate on the falling edge and samples the outputs one nanosecond later, before the next rising edge, so each check sees the state left by all earlier edges. Cycle offsets are counted from the grant: a divide is held for exactly 24 further cycles and granted at offset 25, and a write-port clash is expected exactly when a later candidate's latency puts its result in a cycle that is already claimed.

// File: rtl/sb_pkg.sv
// Shared types for the issue scoreboard.
// Assumes a two-bit operation class field decoded by the issue stage.
package sb_pkg;
    typedef enum logic [1:0] {
        OPC_INT = 2'd0,
        OPC_ADD = 2'd1,
        OPC_MUL = 2'd2,
        OPC_DIV = 2'd3
    } opclass_e;
endpackage

// File: rtl/sb_regrsv.sv
// Per-register reservation flags.
// Reports whether either source or the destination of a candidate is
// reserved. A writeback in the current cycle is honoured at once (the
// cleared register no longer holds the candidate). Register 0 is never
// reserved. Assumes NREG is a power of two.
module sb_regrsv #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic [RW-1:0] dst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    output logic          src_hit,
    output logic          dst_hit
);
    logic [NREG-1:0] rsv_q;
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] live;

    // Decode the clear and set requests into one-hot masks; entry 0 stays empty.
    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_mask
            if (gi == 0) begin : g_zero
                assign clr_mask[gi] = 1'b0;
                assign set_mask[gi] = 1'b0;
            end else begin : g_reg
                assign clr_mask[gi] = clr_en && (clr_reg == RW'(gi));
                assign set_mask[gi] = set_en && (dst == RW'(gi));
            end
        end
    endgenerate

    // Reservations that still stand once this cycle's writeback is applied.
    assign live = rsv_q & ~clr_mask;

    // Look up the candidate's registers against the standing reservations.
    always_comb begin
        src_hit = live[src_a] || live[src_b];
        dst_hit = live[dst];
    end

    // Apply the writeback clear, then the issue set (set wins on a tie).
    always_ff @(posedge clk) begin
        if (!rst_n) rsv_q <= '0;
        else        rsv_q <= live | set_mask;
    end

    // R6: register 0 never shows a reservation.
    a_r6_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        !rsv_q[0]);
    // R4: a granted nonzero destination is reserved in the next cycle.
    a_r4_set_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && dst != '0) |=> rsv_q[$past(dst)]);
    // R5: a writeback lifts the reservation unless the same register is claimed again.
    a_r5_clear_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && dst == clr_reg)) |=> !rsv_q[$past(clr_reg)]);
endmodule

// File: rtl/sb_wbport.sv
// Write-port calendar.
// Bit i of the calendar means a result already uses the register write
// port i cycles from now. A candidate with latency L conflicts if bit L
// is set. A claim marks bit L for the next cycle's view after the shift.
// Assumes 1 <= lat <= MAXLAT.
module sb_wbport #(
    parameter int MAXLAT = 25,
    parameter int LW     = $clog2(MAXLAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lat,
    input  logic          claim,
    output logic          taken
);
    logic [MAXLAT:0] slot_q;
    logic [MAXLAT:0] slot_d;

    // The calendar entry the candidate's result would land on.
    assign taken = slot_q[lat];

    // Advance the calendar by one cycle and add the new claim.
    genvar gi;
    generate
        for (gi = 0; gi <= MAXLAT; gi++) begin : g_slot
            if (gi == MAXLAT) begin : g_top
                assign slot_d[gi] = 1'b0;
            end else begin : g_mid
                assign slot_d[gi] = slot_q[gi+1] || (claim && (lat == LW'(gi + 1)));
            end
        end
    endgenerate

    // Hold the calendar.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R9: a claim is visible one cycle later, one step closer.
    a_r9_claim_lands: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> slot_q[$past(lat) - 1'b1]);
    // R9: a claim is never made on an entry already in use.
    a_r9_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> !taken);
endmodule

// File: rtl/sb_divbusy.sv
// Occupancy tracker for the non-pipelined divider.
// A start in cycle t keeps the unit busy for cycles t+1 .. t+II-1.
// Assumes II >= 2.
module sb_divbusy #(
    parameter int II = 25,
    parameter int CW = $clog2(II)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Load the remaining busy cycles on a start, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= CW'(II - 1);
        else if (busy)  cnt_q <= cnt_q - 1'b1;
    end

    // R7: a start makes the unit busy in the following cycle.
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R7: no start is accepted while busy.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/issue_scoreboard.sv
// In-order issue scoreboard.
// Holds a candidate on a reserved source (RAW) or destination (WAW), on a
// busy divider, or on a claimed write-port cycle. Ordering of operand
// reads covers WAR. Destination 0 means no result. All outputs are
// combinational in the current inputs and state.
module issue_scoreboard #(
    parameter int NREG    = 32,
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 4,
    parameter int LAT_MUL = 7,
    parameter int LAT_DIV = 25,
    localparam int RW     = $clog2(NREG),
    localparam int MAX_AB = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD,
    localparam int MAX_MD = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV,
    localparam int MAXLAT = (MAX_AB > MAX_MD) ? MAX_AB : MAX_MD,
    localparam int LW     = $clog2(MAXLAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [1:0]    issue_op,
    input  logic [RW-1:0] issue_src_a,
    input  logic [RW-1:0] issue_src_b,
    input  logic [RW-1:0] issue_dst,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_reg,
    output logic          issue_grant,
    output logic          stall_raw,
    output logic          stall_waw,
    output logic          stall_unit,
    output logic          stall_port
);
    import sb_pkg::*;

    opclass_e      op;
    logic [LW-1:0] lat;
    logic          has_dst;
    logic          src_hit;
    logic          dst_hit;
    logic          div_busy;
    logic          port_taken;
    logic          is_div;

    assign op      = opclass_e'(issue_op);
    assign has_dst = (issue_dst != '0);
    assign is_div  = (op == OPC_DIV);

    // Latency of the candidate's class.
    always_comb begin
        unique case (op)
            OPC_INT: lat = LW'(LAT_INT);
            OPC_ADD: lat = LW'(LAT_ADD);
            OPC_MUL: lat = LW'(LAT_MUL);
            default: lat = LW'(LAT_DIV);
        endcase
    end

    // Gather the hold reasons and form the grant.
    always_comb begin
        stall_raw   = src_hit;
        stall_waw   = dst_hit;
        stall_unit  = is_div && div_busy;
        stall_port  = has_dst && port_taken;
        issue_grant = issue_valid && !(stall_raw || stall_waw || stall_unit || stall_port);
    end

    sb_regrsv #(.NREG(NREG), .RW(RW)) u_rsv (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_a   (issue_src_a),
        .src_b   (issue_src_b),
        .dst     (issue_dst),
        .set_en  (issue_grant),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .src_hit (src_hit),
        .dst_hit (dst_hit)
    );

    sb_wbport #(.MAXLAT(MAXLAT), .LW(LW)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .lat   (lat),
        .claim (issue_grant && has_dst),
        .taken (port_taken)
    );

    sb_divbusy #(.II(LAT_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue_grant && is_div),
        .busy  (div_busy)
    );

    // R10: nothing is granted without a valid candidate.
    a_r10_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !issue_grant);
    // R7: a granted divide keeps the next divide out in the following cycle.
    a_r7_div_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && is_div) |=> (is_div |-> stall_unit));
    // R8: pipelined classes never see a unit hold.
    a_r8_pipe_free: assert property (@(posedge clk) disable iff (!rst_n)
        !is_div |-> !stall_unit);
endmodule

// File: tb/tb_issue_scoreboard.sv
module tb_issue_scoreboard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       issue_valid;
    logic [1:0] issue_op;
    logic [4:0] issue_src_a, issue_src_b, issue_dst;
    logic       wb_valid;
    logic [4:0] wb_reg;
    logic       issue_grant, stall_raw, stall_waw, stall_unit, stall_port;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    issue_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_src_a(issue_src_a), .issue_src_b(issue_src_b), .issue_dst(issue_dst),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .issue_grant(issue_grant),
        .stall_raw(stall_raw), .stall_waw(stall_waw), .stall_unit(stall_unit),
        .stall_port(stall_port)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Drive a candidate (and an optional writeback) for the coming cycle, settle, then return.
    task automatic drive(input logic v, input logic [1:0] op, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d,
                         input logic wv, input logic [4:0] wr);
        @(negedge clk);
        issue_valid = v; issue_op = op; issue_src_a = a; issue_src_b = b;
        issue_dst = d; wb_valid = wv; wb_reg = wr;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        issue_valid = 1'b0; issue_op = 2'd0; issue_src_a = '0; issue_src_b = '0;
        issue_dst = '0; wb_valid = 1'b0; wb_reg = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R4 R5 R9: dependency holds, port clash and same-cycle clear.
    task automatic t_dependencies();
        do_reset();
        drive(1, 2'd1, 5'd2, 5'd3, 5'd1, 0, 0);          // c0 add r1, wb c4
        check("R1", "grant after reset", issue_grant, 1'b1);
        check("R1", "no hold after reset", stall_raw | stall_waw | stall_unit | stall_port, 1'b0);
        drive(1, 2'd0, 5'd1, 5'd0, 5'd4, 0, 0);          // c1 reads r1
        check("R2", "raw hold", stall_raw, 1'b1);
        check("R2", "raw no grant", issue_grant, 1'b0);
        drive(1, 2'd0, 5'd2, 5'd3, 5'd1, 0, 0);          // c2 writes r1
        check("R3", "waw hold", stall_waw, 1'b1);
        check("R3", "waw no grant", issue_grant, 1'b0);
        drive(1, 2'd0, 5'd4, 5'd0, 5'd6, 0, 0);          // c3 int, wb c4 clashes
        check("R9", "port hold", stall_port, 1'b1);
        check("R4", "held r4 not reserved", stall_raw, 1'b0);
        drive(1, 2'd0, 5'd4, 5'd0, 5'd6, 1, 5'd1);       // c4 int r6, add writes back r1
        check("R9", "port free one cycle later", issue_grant, 1'b1);
        drive(1, 2'd0, 5'd6, 5'd0, 5'd8, 1, 5'd6);       // c5 reads r6 as it writes back
        check("R5", "same-cycle clear lets read issue", issue_grant, 1'b1);
        drive(1, 2'd0, 5'd1, 5'd0, 5'd9, 0, 0);          // c6 reads r1 cleared at c4
        check("R5", "cleared reg readable", issue_grant, 1'b1);
        drive(1, 2'd0, 5'd0, 5'd0, 5'd8, 1, 5'd8);       // c7 rewrites r8 as it writes back
        check("R5", "same-cycle clear lets write issue", issue_grant, 1'b1);
        idle();
    endtask

    // R6: register 0 neither reserves nor claims the port.
    task automatic t_reg_zero();
        do_reset();
        drive(1, 2'd1, 5'd1, 5'd2, 5'd0, 0, 0);          // c0 add to r0
        check("R6", "add to r0 grant", issue_grant, 1'b1);
        drive(1, 2'd0, 5'd0, 5'd0, 5'd0, 0, 0);          // c1
        check("R6", "r0 src/dst no hold", issue_grant, 1'b1);
        idle();                                           // c2
        drive(1, 2'd0, 5'd0, 5'd0, 5'd7, 0, 0);          // c3 int, wb c4
        check("R6", "r0 result claimed no port", stall_port, 1'b0);
        idle();
    endtask

    // R7 R8: divider occupancy and pipelined units alongside it.
    task automatic t_divider();
        do_reset();
        drive(1, 2'd3, 5'd2, 5'd3, 5'd1, 0, 0);          // c0 div
        check("R7", "first div grant", issue_grant, 1'b1);
        drive(1, 2'd3, 5'd2, 5'd3, 5'd4, 0, 0);          // c1
        check("R7", "second div held", stall_unit, 1'b1);
        drive(1, 2'd2, 5'd2, 5'd3, 5'd5, 0, 0);          // c2 mul
        check("R8", "mul during div", issue_grant, 1'b1);
        drive(1, 2'd2, 5'd2, 5'd3, 5'd6, 0, 0);          // c3 mul back to back
        check("R8", "mul back to back", issue_grant, 1'b1);
        for (int c = 4; c < 24; c++) idle();
        drive(1, 2'd3, 5'd2, 5'd3, 5'd4, 0, 0);          // c24
        check("R7", "div held at +24", stall_unit, 1'b1);
        drive(1, 2'd3, 5'd2, 5'd3, 5'd4, 0, 0);          // c25
        check("R7", "div granted at +25", issue_grant, 1'b1);
        idle();
    endtask

    // R10: an invalid candidate is neither granted nor reserves.
    task automatic t_valid_low();
        do_reset();
        drive(0, 2'd1, 5'd2, 5'd3, 5'd1, 0, 0);
        check("R10", "no grant when invalid", issue_grant, 1'b0);
        drive(1, 2'd0, 5'd1, 5'd0, 5'd2, 0, 0);
        check("R4", "invalid reserved nothing", issue_grant, 1'b1);
        idle();
    endtask

    // R8 R9: class latencies decide the write-port cycle.
    task automatic t_latencies();
        do_reset();
        drive(1, 2'd2, 5'd0, 5'd0, 5'd1, 0, 0);          // c0 mul, wb c7
        check("R8", "mul grant", issue_grant, 1'b1);
        idle(); idle();                                   // c1 c2
        drive(1, 2'd1, 5'd0, 5'd0, 5'd2, 0, 0);          // c3 add -> c7 clash
        check("R9", "add clashes with mul", stall_port, 1'b1);
        drive(1, 2'd1, 5'd0, 5'd0, 5'd2, 0, 0);          // c4 add -> c8
        check("R9", "add next cycle grant", issue_grant, 1'b1);
        idle();                                           // c5
        drive(1, 2'd0, 5'd0, 5'd0, 5'd3, 0, 0);          // c6 int -> c7 clash
        check("R9", "int clashes with mul", stall_port, 1'b1);
        drive(1, 2'd0, 5'd0, 5'd0, 5'd3, 0, 0);          // c7 int -> c8 clash
        check("R9", "int clashes with add", stall_port, 1'b1);
        drive(1, 2'd0, 5'd0, 5'd0, 5'd3, 0, 0);          // c8 int -> c9
        check("R9", "int granted on free cycle", issue_grant, 1'b1);
        idle();
    endtask

    initial begin
        fork
            begin
                t_dependencies();
                t_reg_zero();
                t_divider();
                t_valid_low();
                t_latencies();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule